// File: doc/BRIEF.md
# Multi-lane DRP Fan-out Bridge

This block turns a single register-level access request into dynamic reconfiguration port (DRP) transactions on transceiver lanes. A request carries a lane select, a write/read flag, an address and write data, and it is qualified by a one-cycle start strobe. The strobe is raised when software writes the control register. The bridge sends the access either to one lane or, when the select is all ones (0xFF), to every lane at once. It holds a busy flag until every addressed lane has answered.

On the lane side, each lane gets its own enable, write-enable, address and write-data outputs, and returns a ready pulse and read data. A broadcast read merges the data of all lanes with a bitwise OR, so a bit reads as set if any lane has it set. Common-channel and per-lane DRP ports look the same to the bridge. A common port is wired as one more lane.

Top module: `drp_fanout_bridge`

## Requirements
- R1: After reset, busy is 0, rd_data is 0, and no lane enable or write-enable is high.
- R2: A start accepted while idle with a select below NUM_LANES drives a one-cycle enable pulse on that lane only. The pulse is high in the cycle after the accepting edge.
- R3: With the write flag at 1, the lane's write-enable is high together with its enable, and the latched address and write data are presented. With the flag at 0, write-enable stays low, and the returned data appears on rd_data at the edge that ends the access.
- R4: busy rises at the edge that accepts a valid start. It falls at the edge where the last outstanding ready is sampled.
- R5: The select value 0xFF pulses the enable of every lane in the same cycle.
- R6: A broadcast ends only after each lane has returned a ready pulse, whatever order and delay the lanes answer in.
- R7: A broadcast read returns on rd_data the bitwise OR of the data returned by all lanes.
- R8: A start raised while busy is 1 is ignored. It produces no enable, and it leaves the address, data and result of the running access unchanged.
- R9: A select at or above NUM_LANES that is not 0xFF produces no enable and never raises busy. It clears rd_data to 0 at the accepting edge.
- R10: A ready pulse from a lane that is not addressed, or that has already answered, is ignored, together with its data.
- R11: A write access leaves rd_data unchanged.
- R12: A running access cannot be aborted. The lane address, write data and write flag stay stable until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle strobe from a control register write |
| req_sel | input | SEL_W | Lane select; all ones means every lane |
| req_wr | input | 1 | 1 = DRP write, 0 = DRP read |
| req_addr | input | ADDR_W | DRP address |
| req_wdata | input | DATA_W | DRP write data |
| busy | output | 1 | Access in progress |
| rd_data | output | DATA_W | Result of the last read (OR-merged on broadcast) |
| lane_en | output | NUM_LANES | Per-lane DRP enable pulse |
| lane_we | output | NUM_LANES | Per-lane DRP write-enable |
| lane_addr | output | NUM_LANES*ADDR_W | Per-lane DRP address, lane i at bits i*ADDR_W |
| lane_wdata | output | NUM_LANES*DATA_W | Per-lane DRP write data, lane i at bits i*DATA_W |
| lane_rdy | input | NUM_LANES | Per-lane DRP ready pulse |
| lane_rdata | input | NUM_LANES*DATA_W | Per-lane DRP read data, lane i at bits i*DATA_W |

## Verification
The bench gives each lane a different reply delay and also reverses the order of the delays. A design that ended a broadcast on the first or on any single ready would drop busy early and return a partial OR. It injects a stray ready carrying 0xDEAD on a lane that is not addressed, which a design without a pending mask would merge or count. It raises a start during a long access and then reads back the target of that ignored write, which exposes any design that relaunches or relatches on a busy start. It issues an out-of-range select after a nonzero read, and a write after a read, so that a design that leaves a stale result or overwrites rd_data on writes is caught.

// File: rtl/drp_fanout_pkg.sv
package drp_fanout_pkg;
  typedef enum logic {
    BR_IDLE = 1'b0,
    BR_WAIT = 1'b1
  } br_state_e;
endpackage

// File: rtl/drp_sel_decode.sv
module drp_sel_decode #(
  parameter int NUM_LANES = 4,
  parameter int SEL_W     = 8
) (
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_LANES-1:0] hit_mask,
  output logic                 invalid
);
  localparam logic [SEL_W-1:0] BCAST_SEL = '1;

  logic bcast;
  assign bcast = (sel == BCAST_SEL);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_hit
    assign hit_mask[i] = bcast | (sel == SEL_W'(i));
  end

  assign invalid = ~|hit_mask;
endmodule

// File: rtl/drp_pend_merge.sv
module drp_pend_merge #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_LANES-1:0]        load_mask,
  input  logic [NUM_LANES-1:0]        lane_rdy,
  input  logic [NUM_LANES*DATA_W-1:0] lane_rdata,
  output logic [NUM_LANES-1:0]        pending,
  output logic [DATA_W-1:0]           acc_next,
  output logic                        last
);
  logic [NUM_LANES-1:0] pend_q, pend_d, hit;
  logic [DATA_W-1:0]    acc_q, acc_d, acc_or;
  logic                 upd_en;

  assign hit = lane_rdy & pend_q;

  always_comb begin
    acc_or = acc_q;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (hit[i]) acc_or = acc_or | lane_rdata[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    pend_d = load ? load_mask : (pend_q & ~hit);
    acc_d  = load ? '0 : acc_or;
    upd_en = load | (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      acc_q  <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      acc_q  <= acc_d;
    end
  end

  assign pending  = pend_q;
  assign acc_next = acc_or;
  assign last     = (|pend_q) & ~|(pend_q & ~hit);

  // R10
  pend_no_new_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/drp_fanout_bridge.sv
module drp_fanout_bridge
  import drp_fanout_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SEL_W     = 8,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_start,
  input  logic [SEL_W-1:0]            req_sel,
  input  logic                        req_wr,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        busy,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_LANES-1:0]        lane_en,
  output logic [NUM_LANES-1:0]        lane_we,
  output logic [NUM_LANES*ADDR_W-1:0] lane_addr,
  output logic [NUM_LANES*DATA_W-1:0] lane_wdata,
  input  logic [NUM_LANES-1:0]        lane_rdy,
  input  logic [NUM_LANES*DATA_W-1:0] lane_rdata
);
  br_state_e            state_q, state_d;
  logic [NUM_LANES-1:0] hit_mask, pending, en_q, en_d;
  logic                 invalid, accept, launch, last;
  logic                 wr_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q, rd_q, rd_d, acc_next;

  drp_sel_decode #(.NUM_LANES(NUM_LANES), .SEL_W(SEL_W)) u_dec (
    .sel      (req_sel),
    .hit_mask (hit_mask),
    .invalid  (invalid)
  );

  drp_pend_merge #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (launch),
    .load_mask  (hit_mask),
    .lane_rdy   (lane_rdy),
    .lane_rdata (lane_rdata),
    .pending    (pending),
    .acc_next   (acc_next),
    .last       (last)
  );

  always_comb begin
    accept  = req_start & (state_q == BR_IDLE);
    launch  = accept & ~invalid;
    en_d    = launch ? hit_mask : '0;
    state_d = state_q;
    rd_d    = rd_q;
    case (state_q)
      BR_IDLE: begin
        if (launch) state_d = BR_WAIT;
        if (accept && invalid) rd_d = '0;
      end
      BR_WAIT: begin
        if (last) begin
          state_d = BR_IDLE;
          if (!wr_q) rd_d = acc_next;
        end
      end
      default: state_d = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BR_IDLE;
      en_q    <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      wr_q    <= req_wr;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign busy    = (state_q == BR_WAIT);
  assign rd_data = rd_q;
  assign lane_en = en_q;
  assign lane_we = en_q & {NUM_LANES{wr_q}};

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_addr[i*ADDR_W +: ADDR_W]  = addr_q;
    assign lane_wdata[i*DATA_W +: DATA_W] = wdata_q;
  end

  // R2
  en_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_en) |=> !(|lane_en));
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  // R6
  busy_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pending != '0));
  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(wdata_q) && $stable(wr_q) && lane_en == '0));
  // R9
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy && invalid) |=> (!busy && rd_data == '0 && lane_en == '0));
  // R11
  wr_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q) |=> $stable(rd_data));
endmodule

// File: tb/sim_drp_fanout_bridge.sv
module sim_drp_fanout_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int SW = 8;
  localparam int AW = 9;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_start;
  logic [SW-1:0] req_sel;
  logic req_wr;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic busy;
  logic [DW-1:0] rd_data;
  logic [N-1:0] lane_en, lane_we, lane_rdy;
  logic [N*AW-1:0] lane_addr;
  logic [N*DW-1:0] lane_wdata, lane_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  drp_fanout_bridge #(.NUM_LANES(N), .SEL_W(SW), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_sel(req_sel),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rd_data(rd_data), .lane_en(lane_en), .lane_we(lane_we),
    .lane_addr(lane_addr), .lane_wdata(lane_wdata),
    .lane_rdy(lane_rdy), .lane_rdata(lane_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // lane responders
  logic [DW-1:0] mem [N][16];
  logic [DW-1:0] held [N];
  logic [DW-1:0] rsp_data [N];
  int cnt [N];
  int lat [N];
  logic [N-1:0] spur;
  logic [N-1:0] en_seen;
  logic [N-1:0] exp_mask;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_wdata;
  logic exp_wr;

  always_comb begin
    for (int i = 0; i < N; i++) lane_rdata[i*DW +: DW] = rsp_data[i];
  end

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      lane_rdy[i] = 1'b0;
      rsp_data[i] = '0;
      if (spur[i]) begin
        lane_rdy[i] = 1'b1;
        rsp_data[i] = 16'hDEAD;
      end
      if (cnt[i] > 0) begin
        cnt[i]--;
        if (cnt[i] == 0) begin
          lane_rdy[i] = 1'b1;
          rsp_data[i] = held[i];
        end
      end
      if (rst_n && busy && exp_mask[i])
        chk(lane_addr[i*AW +: AW] == exp_addr && lane_wdata[i*DW +: DW] == exp_wdata,
            "R12", 32'(lane_addr[i*AW +: AW]), 32'(exp_addr));
      if (lane_en[i]) begin
        en_seen[i] = 1'b1;
        chk(exp_mask[i], "R2", 32'(i), 32'(exp_mask));
        chk(lane_we[i] == exp_wr, "R3", 32'(lane_we[i]), 32'(exp_wr));
        if (lane_we[i]) mem[i][lane_addr[i*AW +: 4]] = lane_wdata[i*DW +: DW];
        held[i] = mem[i][lane_addr[i*AW +: 4]];
        cnt[i] = lat[i];
      end
    end
  end

  // behavioural reference model, advanced on every rising edge
  int m_q[$];
  bit m_busy;
  bit m_wr;
  logic [DW-1:0] m_rd, m_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_rd = '0; m_acc = '0; m_q.delete();
    end else if (m_busy) begin
      for (int i = 0; i < N; i++) begin
        if (lane_rdy[i]) begin
          for (int k = 0; k < m_q.size(); k++) begin
            if (m_q[k] == i) begin
              m_q.delete(k);
              if (!m_wr) m_acc = m_acc | lane_rdata[i*DW +: DW];
              break;
            end
          end
        end
      end
      if (m_q.size() == 0) begin
        m_busy = 0;
        if (!m_wr) m_rd = m_acc;
      end
    end else if (req_start) begin
      if (req_sel == 8'hFF) begin
        for (int i = 0; i < N; i++) m_q.push_back(i);
      end else if (int'(req_sel) < N) begin
        m_q.push_back(int'(req_sel));
      end
      if (m_q.size() == 0) m_rd = '0;
      else begin
        m_busy = 1; m_wr = req_wr; m_acc = '0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R4", 32'(busy), 32'(m_busy));
      chk(rd_data == m_rd, "R7", 32'(rd_data), 32'(m_rd));
    end
  end

  task automatic access(input logic [SW-1:0] s, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    req_sel = s; req_wr = w; req_addr = a; req_wdata = d; req_start = 1'b1;
    exp_addr = a; exp_wdata = d; exp_wr = w; en_seen = '0;
    exp_mask = (s == 8'hFF) ? '1 : ((int'(s) < N) ? N'(1) << s : '0);
    @(negedge clk);
    req_start = 1'b0;
    while (busy) @(negedge clk);
    chk(en_seen == exp_mask, tag, 32'(en_seen), 32'(exp_mask));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      cnt[i] = 0; lat[i] = i + 1;
      for (int k = 0; k < 16; k++) mem[i][k] = '0;
    end
    spur = '0; exp_mask = '0; exp_addr = '0; exp_wdata = '0; exp_wr = 0; en_seen = '0;
    req_start = 0; req_sel = '0; req_wr = 0; req_addr = '0; req_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", 32'(busy), 0);
    chk(rd_data == '0, "R1", 32'(rd_data), 0);
    chk(lane_en == '0 && lane_we == '0, "R1", 32'(lane_en), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3: single-lane write then read
    access(8'd2, 1'b1, 9'd5, 16'h1234, "R2");
    access(8'd2, 1'b0, 9'd5, 16'h0, "R3");
    chk(rd_data == 16'h1234, "R3", 32'(rd_data), 32'h1234);

    // R10: stray ready on lane 3 during a lane 1 read
    fork
      access(8'd1, 1'b0, 9'd5, 16'h0, "R10");
      begin @(negedge clk); @(negedge clk); spur[3] = 1'b1; @(negedge clk); spur[3] = 1'b0; end
    join
    chk(rd_data == 16'h0, "R10", 32'(rd_data), 0);

    // R5: broadcast write, read back each lane
    access(8'hFF, 1'b1, 9'd3, 16'h0A50, "R5");
    for (int i = 0; i < N; i++) begin
      access(SW'(i), 1'b0, 9'd3, 16'h0, "R5");
      chk(rd_data == 16'h0A50, "R5", 32'(rd_data), 32'h0A50);
    end

    // R6 R7: distinct data per lane, reversed latencies, broadcast read = OR
    for (int i = 0; i < N; i++) access(SW'(i), 1'b1, 9'd7, 16'h0001 << (i*3), "R6");
    for (int i = 0; i < N; i++) lat[i] = 2*(N - i) + 1;
    access(8'hFF, 1'b0, 9'd7, 16'h0, "R6");
    chk(rd_data == 16'h0249, "R7", 32'(rd_data), 32'h0249);

    // R8: start while busy is ignored
    lat[1] = 8;
    @(negedge clk);
    req_sel = 8'd1; req_wr = 0; req_addr = 9'd7; req_wdata = '0; req_start = 1;
    exp_addr = 9'd7; exp_wdata = '0; exp_wr = 0; exp_mask = 4'b0010; en_seen = '0;
    @(negedge clk);
    req_sel = 8'd0; req_wr = 1; req_addr = 9'd9; req_wdata = 16'hFFFF;
    repeat (2) @(negedge clk);
    req_start = 0;
    while (busy) @(negedge clk);
    chk(en_seen == 4'b0010, "R8", 32'(en_seen), 32'h2);
    chk(rd_data == 16'h0008, "R8", 32'(rd_data), 32'h8);
    access(8'd0, 1'b0, 9'd9, 16'h0, "R8");
    chk(rd_data == 16'h0000, "R8", 32'(rd_data), 0);

    // R11: write leaves rd_data alone
    access(8'd2, 1'b0, 9'd5, 16'h0, "R11");
    access(8'd2, 1'b1, 9'd6, 16'h5555, "R11");
    chk(rd_data == 16'h1234, "R11", 32'(rd_data), 32'h1234);

    // R9: out-of-range select clears rd_data, never busy
    @(negedge clk);
    req_sel = 8'd6; req_wr = 0; req_addr = 9'd5; req_start = 1;
    exp_mask = '0; en_seen = '0;
    @(negedge clk);
    req_start = 0;
    chk(busy == 0, "R9", 32'(busy), 0);
    chk(rd_data == '0, "R9", 32'(rd_data), 0);
    repeat (3) @(negedge clk);
    chk(en_seen == '0, "R9", 32'(en_seen), 0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule